// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Responder

This block answers a two-wire serial EEPROM protocol one bit at a time. A register block that bit-bangs the bus hands it sampled clock and data levels. Each sample arrives with a one-cycle strobe. The block keeps the previous levels and uses them to classify each new sample:

- a start (data falls while the clock stays high);
- a stop (data rises while the clock stays high);
- a data bit (the clock rises while data holds its level).

After a start the block shifts in an eight-bit command and acknowledges it. It then shifts in an eight-bit address. If the command's last bit marks a read, it drives out the byte it holds, MSB first, during those same eight clock pulses. On the eighth address bit it loads the byte stored at that address into its holding register and acknowledges again. It then drops back to idle, so every access opens with a new start.

The byte store is a read-only table fixed at elaboration by a parameter, with 256 entries by default or 128 entries as a variant (the 128-entry variant addresses on the low seven bits). The current data-line level is available as a single readback bit. Software reads that bit to see both its own samples and the acknowledge and read data this block drives.

Top module: `i2cee_slave`

## Requirements
- R1: After reset the readback bit is 1, no transaction is in progress and the holding byte is 0x00. The first read-mode transaction after reset therefore shows eight zero bits.
- R2: In idle (no start since reset, or since the last address acknowledge), clock pulses are not counted and never produce a low acknowledge. The readback equals the most recent data sample.
- R3: A start condition restarts command reception at its first bit, discarding any command bits already taken. A start condition is data 1 in the previous sample and 0 in the new one, with the clock 1 in both.
- R4: Command bits are taken MSB first, one on each clock rise (clock 0 in the previous sample, 1 in the new one) whose data level equals the previous sample's. On the clock rise that follows the eighth bit, the readback goes to 0 (acknowledge). The next sample releases it.
- R5: After the command acknowledge, eight address bits are taken the same way, MSB first. The clock rise after them drives the acknowledge 0, and the block then returns to idle.
- R6: When the command's last bit is 1 (read), each address-bit clock rise sets the readback to the next holding-byte bit, MSB first. When it is 0 (write), the readback shows the sampled data.
- R7: On the eighth address bit the holding byte is loaded from the store at that address. With default contents, the byte at address a is (29*a + 90) mod 256.
- R8: A sample in which the clock rises and the data level changes at the same time is not a bit and does not advance the count.
- R9: A stop condition is not a bit and leaves the count and any pending acknowledge unchanged. A stop condition is data 0 in the previous sample and 1 in the new one, with the clock 1 in both.
- R10: The readback changes only one clock after a sample strobe. It equals the sampled data level, except when the block drives an acknowledge or a read bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe: a new bus sample is present |
| smp_scl | input | 1 | Sampled clock-line level |
| smp_sda | input | 1 | Sampled data-line level |
| sda_rb | output | 1 | Current data-line level as seen and driven by the responder |

## Verification
Every result of this block is due exactly one clock after the strobe that caused it, because all state loads on the strobe edge. The bench drives each sample on a falling edge and queues the level expected for that sample. A monitor then compares the readback on the next falling edge, after the rising edge that consumed the strobe. Acknowledge and read bits are expected on the clock-high sample, since that is the sample that advances the count. Extra cycles without a strobe are inserted to confirm that the readback holds between samples.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 256;
  localparam int TICK_W    = 5;
  localparam int CMD_END   = BYTE_W + 1;
  localparam int ADR_END   = 2 * BYTE_W + 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic steady;
  } bus_ev_t;

  function automatic logic [MAX_BYTES*BYTE_W-1:0] fill_pattern(
    input logic [BYTE_W-1:0] mul,
    input logic [BYTE_W-1:0] ofs
  );
    logic [MAX_BYTES*BYTE_W-1:0] v;
    v = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      v[i*BYTE_W +: BYTE_W] = BYTE_W'(i * int'(mul) + int'(ofs));
    end
    return v;
  endfunction
endpackage

// File: rtl/i2cee_edge.sv
module i2cee_edge
  import i2cee_pkg::*;
(
  input  logic    scl_q,
  input  logic    sda_q,
  input  logic    scl_in,
  input  logic    sda_in,
  output bus_ev_t ev
);
  logic both_high;

  always_comb begin
    both_high = scl_q & scl_in;
    ev.start  = both_high & sda_q & ~sda_in;
    ev.stop   = both_high & ~sda_q & sda_in;
    ev.rise   = ~scl_q & scl_in;
    ev.steady = (sda_q == sda_in);
  end
endmodule

// File: rtl/i2cee_rom.sv
module i2cee_rom
  import i2cee_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter logic [MAX_BYTES*BYTE_W-1:0] INIT = fill_pattern(8'd29, 8'd90)
) (
  input  logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] data
);
  localparam int AW = $clog2(DEPTH);

  generate
    if (AW >= BYTE_W) begin : g_full
      always_comb data = INIT[addr*BYTE_W +: BYTE_W];
    end else begin : g_part
      logic [AW-1:0] idx;
      always_comb begin
        idx  = addr[AW-1:0];
        data = INIT[idx*BYTE_W +: BYTE_W];
      end
    end
  endgenerate
endmodule

// File: rtl/i2cee_seq.sv
module i2cee_seq
  import i2cee_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic              scl_in,
  input  logic              sda_in,
  input  bus_ev_t           ev,
  input  logic [BYTE_W-1:0] rom_data,
  output logic [BYTE_W-1:0] fetch_addr,
  output logic              scl_q,
  output logic              sda_q,
  output logic [TICK_W-1:0] tick_q,
  output logic              ack_q,
  output logic [BYTE_W-1:0] cmd_q
);
  localparam logic [TICK_W-1:0] T_ONE  = TICK_W'(1);
  localparam logic [TICK_W-1:0] T_CEND = TICK_W'(CMD_END);
  localparam logic [TICK_W-1:0] T_AEND = TICK_W'(ADR_END);

  logic [BYTE_W-1:0] addr_q, data_q;
  logic [BYTE_W-1:0] addr_d, data_d, cmd_d;
  logic [TICK_W-1:0] tick_d;
  logic              scl_d, sda_d, ack_d;
  logic              idle;

  assign fetch_addr = {addr_q[BYTE_W-2:0], sda_in};
  assign idle       = (tick_q == '0) && !ack_q;

  always_comb begin
    scl_d  = scl_in;
    sda_d  = sda_in;
    tick_d = tick_q;
    ack_d  = ack_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    if (ev.start || ev.stop) begin
      if (ev.start) begin
        tick_d = T_ONE;
        cmd_d  = '0;
      end
    end else if (idle) begin
      tick_d = tick_q;
    end else if (ev.rise) begin
      if (ack_q) begin
        sda_d = 1'b0;
        ack_d = 1'b0;
      end else if (ev.steady) begin
        if (tick_q < T_CEND) begin
          cmd_d  = {cmd_q[BYTE_W-2:0], sda_in};
          tick_d = tick_q + T_ONE;
          if (tick_q == T_CEND - T_ONE) ack_d = 1'b1;
        end else if (tick_q < T_AEND) begin
          if (cmd_q[0]) sda_d = data_q[BYTE_W-1];
          addr_d = fetch_addr;
          data_d = data_q << 1;
          tick_d = tick_q + T_ONE;
          if (tick_q == T_AEND - T_ONE) begin
            data_d = rom_data;
            ack_d  = 1'b1;
            tick_d = '0;
          end
        end else begin
          sda_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      tick_q <= '0;
      ack_q  <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (smp_vld) begin
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      tick_q <= tick_d;
      ack_q  <= ack_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter logic [MAX_BYTES*BYTE_W-1:0] INIT = fill_pattern(8'd29, 8'd90)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  logic smp_scl,
  input  logic smp_sda,
  output logic sda_rb
);
  bus_ev_t           ev;
  logic              scl_q, sda_q_w, ack_q;
  logic [TICK_W-1:0] tick_q;
  logic [BYTE_W-1:0] cmd_q, fetch_addr, rom_data;

  i2cee_edge u_edge (
    .scl_q  (scl_q),
    .sda_q  (sda_q_w),
    .scl_in (smp_scl),
    .sda_in (smp_sda),
    .ev     (ev)
  );

  i2cee_rom #(.DEPTH(DEPTH), .INIT(INIT)) u_rom (
    .addr (fetch_addr),
    .data (rom_data)
  );

  i2cee_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .scl_in     (smp_scl),
    .sda_in     (smp_sda),
    .ev         (ev),
    .rom_data   (rom_data),
    .fetch_addr (fetch_addr),
    .scl_q      (scl_q),
    .sda_q      (sda_q_w),
    .tick_q     (tick_q),
    .ack_q      (ack_q),
    .cmd_q      (cmd_q)
  );

  assign sda_rb = sda_q_w;
endmodule

// File: rtl/i2cee_chk.sv
module i2cee_chk
  import i2cee_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smp_vld,
  input logic              smp_scl,
  input logic              smp_sda,
  input logic              sda_rb,
  input logic              scl_q,
  input logic              sda_q,
  input logic              ack_q,
  input logic [TICK_W-1:0] tick_q,
  input logic [BYTE_W-1:0] cmd_q
);
  AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(sda_rb)); // R10

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && tick_q == '0 && !ack_q) |=> (sda_rb == $past(smp_sda))); // R2

  AST_ACK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && ack_q && !scl_q && smp_scl) |=> (!sda_rb && !ack_q)); // R4

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && scl_q && smp_scl && sda_q && !smp_sda)
      |=> (tick_q == TICK_W'(1) && cmd_q == '0)); // R3

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < TICK_W'(ADR_END)); // R5

  AST_SKEW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !ack_q && !scl_q && smp_scl && (sda_q != smp_sda))
      |=> $stable(tick_q)); // R8

  AST_STOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && scl_q && smp_scl && !sda_q && smp_sda)
      |=> ($stable(tick_q) && $stable(ack_q))); // R9
endmodule

bind i2cee_slave i2cee_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_vld (smp_vld),
  .smp_scl (smp_scl),
  .smp_sda (smp_sda),
  .sda_rb  (sda_rb),
  .scl_q   (scl_q),
  .sda_q   (sda_q_w),
  .ack_q   (ack_q),
  .tick_q  (tick_q),
  .cmd_q   (cmd_q)
);

// File: tb/sim_i2cee_slave.sv
`timescale 1ns/1ps
module sim_i2cee_slave;
  logic clk = 1'b0;
  logic rst_n, smp_vld, smp_scl, smp_sda;
  wire  sda_rb;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic fire  = 1'b0;
  logic [7:0] held;

  logic  expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  i2cee_slave u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .smp_scl(smp_scl), .smp_sda(smp_sda), .sda_rb(sda_rb)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((29 * a + 90) % 256); // R7 default contents
  endfunction

  function automatic void check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: readback %b expected %b at %0t", tag, act, exp, $time);
    end
  endfunction

  always @(posedge clk) fire <= smp_vld;

  always @(negedge clk) begin
    if (fire && expq.size() > 0) begin
      check(sda_rb, expq.pop_front(), tagq.pop_front());
    end
  end

  task automatic step(input logic scl, input logic sda, input logic exp, input string tag);
    @(negedge clk);
    smp_vld = 1'b1; smp_scl = scl; smp_sda = sda;
    expq.push_back(exp); tagq.push_back(tag);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic send_bit(input logic b, input logic exp_hi, input string tag);
    step(1'b0, b, b, tag);
    step(1'b1, b, exp_hi, tag);
  endtask

  task automatic ack_slot(input string tag);
    step(1'b0, 1'b1, 1'b1, tag);
    step(1'b1, 1'b1, 1'b0, tag);
  endtask

  task automatic go_start(input string tag);
    step(1'b0, 1'b1, 1'b1, tag);
    step(1'b1, 1'b1, 1'b1, tag);
    step(1'b1, 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic cmd_byte(input logic [7:0] c, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(c[i], c[i], tag);
  endtask

  task automatic addr_byte(input logic rd, input logic [7:0] a, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(a[i], rd ? held[i] : a[i], tag);
    ack_slot("R5 address ack");
    held = mem_byte(int'(a));
  endtask

  task automatic txn(input logic [7:0] c, input logic [7:0] a, input string tag);
    go_start("R3 start");
    cmd_byte(c, "R4 command bit");
    ack_slot("R4 command ack");
    addr_byte(c[0], a, tag);
  endtask

  task automatic hold_check(input logic exp, input string tag);
    repeat (4) @(negedge clk);
    check(sda_rb, exp, tag);
  endtask

  task automatic idle_bits(input logic [8:0] pat, input string tag);
    for (int i = 8; i >= 0; i--) send_bit(pat[i], pat[i], tag);
  endtask

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp_scl = 1'b1; smp_sda = 1'b1;
    held = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sda_rb, 1'b1, "R1 reset readback");

    idle_bits(9'b1_0110_1001, "R2 idle before start");
    hold_check(1'b1, "R10 hold without strobe");

    txn(8'hA1, 8'h3C, "R1 R6 read after reset gives zeros");
    hold_check(1'b0, "R10 ack held without strobe");
    idle_bits(9'b0_1100_1011, "R2 R5 idle after address ack");

    txn(8'hA0, 8'h05, "R6 write mode passes sample");
    txn(8'hA1, 8'hFF, "R7 read of byte 0x05");
    txn(8'hA1, 8'h80, "R7 read of byte 0xFF");

    // R8: clock rise with data change inside the command byte
    go_start("R3 start");
    for (int i = 7; i >= 5; i--) send_bit(1'(8'hA1 >> i), 1'(8'hA1 >> i), "R8 command bit");
    step(1'b0, 1'b0, 1'b0, "R8 skew low");
    step(1'b1, 1'b1, 1'b1, "R8 skew ignored");
    for (int i = 4; i >= 0; i--) send_bit(1'(8'hA1 >> i), 1'(8'hA1 >> i), "R8 command bit");
    ack_slot("R8 ack after eight real bits");
    addr_byte(1'b1, 8'h00, "R7 R8 read of byte 0x80");

    // R9: stop after the second command bit (a 0)
    go_start("R3 start");
    send_bit(1'b1, 1'b1, "R9 command bit");
    send_bit(1'b0, 1'b0, "R9 command bit");
    step(1'b1, 1'b1, 1'b1, "R9 stop passes level");
    for (int i = 5; i >= 0; i--) send_bit(1'(8'hA1 >> i), 1'(8'hA1 >> i), "R9 command bit");
    ack_slot("R9 ack count unchanged by stop");
    addr_byte(1'b1, 8'h7F, "R9 read of byte 0x00");

    // R3: restart after two command bits
    go_start("R3 start");
    send_bit(1'b1, 1'b1, "R3 partial bit");
    send_bit(1'b1, 1'b1, "R3 partial bit");
    step(1'b1, 1'b0, 1'b0, "R3 restart");
    step(1'b0, 1'b0, 1'b0, "R3 restart");
    cmd_byte(8'hA1, "R3 command after restart");
    ack_slot("R3 ack after full byte");
    addr_byte(1'b1, 8'h10, "R3 R7 read of byte 0x7F");

    txn(8'hA1, 8'h10, "R7 read of byte 0x10");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule